// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog for a larger chip. It sits behind a simple 32-bit register port. Every register is one word, and the byte offset selects it. A down-counter is loaded from a programmable reload word and loses one count on each 1 MHz tick-enable pulse. Software keeps the counter from running out by writing a fixed 16-bit key into a write-only restart register. Any other value written there has no effect.

When the counter runs out, the block emits a one-cycle expiry pulse. If the reset-system control bit is set, it also drives a reset output for a programmed number of ticks. The active level and the drive-mode indication of that output can only be changed by writing particular key bytes into the top byte of the reset-width register. Plain bits in that register do not change them. An external flag from the memory controller can veto an expiry. When the flag is high, the timer shuts itself off quietly and produces no pulse.

Top module: `kwd_top`

## Requirements
- R1: After reset, offset 0x00 (count) and offset 0x04 (reload) read 0x014FB180, control (0x0C) reads 0x00000010, reset-width (0x18) reads 0x000000FF, and the mask word (0x1C) reads 0.
- R2: Reads return the count at 0x00, reload at 0x04, control at 0x0C, reset-width at 0x18 and the mask word at 0x1C (which reads back whatever was written). The restart offset 0x08, any unused or unaligned offset, and 0x10 and 0x14 read 0. A write to 0x00 has no effect.
- R3: A control write is stored with bits 11:8 forced to 0 and bit 4 forced to 1.
- R4: Control bit 0 is enable and bit 1 is reset-system. A control write that raises enable loads the counter from reload and starts it. A control write that drops enable freezes the counter at its value. A control write that leaves enable unchanged does not alter the count.
- R5: A write to 0x08 whose low 16 bits equal 0x4755 loads the counter from reload, and the counter runs if enable is set. Any other value changes nothing.
- R6: While running, each tick lowers the count by one. A tick that finds the count at 1 or 0 sets it to 0 and stops it, and `expire_pulse` is high for exactly the one following cycle.
- R7: In a cycle that carries both a tick and a control write or a keyed restart, the tick is dropped and the write alone decides the count.
- R8: If `mc_reset_flag` is high on the expiring tick, the count becomes 0, the counter stops, control reads 0, and neither `expire_pulse` nor the reset output is produced.
- R9: A reset-width write stores its bits 19:0 as the pulse width, and bits 29:20 always read 0. The top byte acts as a key: 0xA5 sets bit 31, 0x5A clears bit 31, 0xA8 sets bit 30, 0x8A clears bit 30, and any other top byte leaves both bits unchanged. `reset_push_pull` follows bit 30.
- R10: On an expiry with reset-system set, `reset_out` goes to its active level (high when bit 31 is 1, low when it is 0) in the same cycle as `expire_pulse`. It stays there for exactly the programmed number of ticks and otherwise sits at the opposite level. A width of 0 gives no active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 1 MHz count-enable pulse, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mc_reset_flag | input | 1 | Memory-controller reset flag; vetoes expiry |
| expire_pulse | output | 1 | One-cycle pulse after an expiry |
| reset_out | output | 1 | Reset output at the programmed level |
| reset_push_pull | output | 1 | Drive-mode indication, 1 = push-pull |

## Verification
A tick and a register write can arrive in the same cycle. The case that matters is the final tick, the one that would expire the counter, landing together with a keyed restart or a control write. The bench sets the count to 1 with ticks held off, then issues the write and the tick together. It expects the newly written value in the count and no expiry pulse. The expiry veto is provoked the same way: the flag is raised exactly on the final tick, and the bench expects control and count at zero with both outputs quiet. A cycle-by-cycle reference model checks every output and the read data on every clock.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int unsigned DW = 32;

    localparam logic [7:0] OFF_COUNT  = 8'h00;
    localparam logic [7:0] OFF_RELOAD = 8'h04;
    localparam logic [7:0] OFF_KICK   = 8'h08;
    localparam logic [7:0] OFF_CTRL   = 8'h0C;
    localparam logic [7:0] OFF_WIDTH  = 8'h18;
    localparam logic [7:0] OFF_MASK   = 8'h1C;

    localparam logic [15:0] KICK_KEY   = 16'h4755;
    localparam logic [7:0]  KEY_LVL_HI = 8'hA5;
    localparam logic [7:0]  KEY_LVL_LO = 8'h5A;
    localparam logic [7:0]  KEY_PP     = 8'hA8;
    localparam logic [7:0]  KEY_OD     = 8'h8A;

    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_ARM  = 1;
    localparam int unsigned WID_LVL  = 31;
    localparam int unsigned WID_PP   = 30;

    typedef enum logic [2:0] {
        SEL_COUNT, SEL_RELOAD, SEL_KICK, SEL_CTRL, SEL_WIDTH, SEL_MASK, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic load;         // copy reload into the counter
        logic run_on_load;  // running state after that copy
        logic stop;         // freeze the counter
        logic hold;         // a bus action owns the counter this cycle
    } cnt_cmd_t;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        case (off)
            OFF_COUNT:  return SEL_COUNT;
            OFF_RELOAD: return SEL_RELOAD;
            OFF_KICK:   return SEL_KICK;
            OFF_CTRL:   return SEL_CTRL;
            OFF_WIDTH:  return SEL_WIDTH;
            OFF_MASK:   return SEL_MASK;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] clean_ctrl(input logic [DW-1:0] d);
        return (d & ~32'h0000_0F00) | 32'h0000_0010;
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 5,
    parameter int unsigned     FIELD_W   = 20,
    parameter logic [DW-1:0]   INIT_LOAD = 32'h014F_B180,
    parameter logic [DW-1:0]   INIT_WID  = 32'h0000_00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              quench,
    input  logic [DW-1:0]     count_val,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     reload_q,
    output logic              arm_q,
    output logic [DW-1:0]     width_q,
    output cnt_cmd_t          cmd
);
    localparam logic [DW-1:0] CTRL_INIT = clean_ctrl('0);

    reg_sel_e      sel;
    logic [DW-1:0] ctrl_q, mask_q, ctrl_new, width_new;
    logic          wr_ctrl, kick_ok;

    assign sel      = decode_off(8'(addr));
    assign ctrl_new = clean_ctrl(wdata);
    assign wr_ctrl  = wr && (sel == SEL_CTRL);
    assign kick_ok  = wr && (sel == SEL_KICK) && (wdata[15:0] == KICK_KEY);

    always_comb begin
        cmd             = '0;
        cmd.hold        = wr_ctrl || kick_ok;
        if (kick_ok) begin
            cmd.load        = 1'b1;
            cmd.run_on_load = ctrl_q[CTL_EN];
        end else if (wr_ctrl && ctrl_new[CTL_EN] && !ctrl_q[CTL_EN]) begin
            cmd.load        = 1'b1;
            cmd.run_on_load = 1'b1;
        end
        cmd.stop = wr_ctrl && !ctrl_new[CTL_EN] && ctrl_q[CTL_EN];
    end

    always_comb begin
        width_new                = width_q;
        width_new[FIELD_W-1:0]   = wdata[FIELD_W-1:0];
        case (wdata[31:24])
            KEY_LVL_HI: width_new[WID_LVL] = 1'b1;
            KEY_LVL_LO: width_new[WID_LVL] = 1'b0;
            KEY_PP:     width_new[WID_PP]  = 1'b1;
            KEY_OD:     width_new[WID_PP]  = 1'b0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= INIT_LOAD;
            ctrl_q   <= CTRL_INIT;
            width_q  <= INIT_WID;
            mask_q   <= '0;
        end else begin
            if (quench) begin
                ctrl_q <= '0;
            end else if (wr_ctrl) begin
                ctrl_q <= ctrl_new;
            end
            if (wr) begin
                case (sel)
                    SEL_RELOAD: reload_q <= wdata;
                    SEL_WIDTH:  width_q  <= width_new;
                    SEL_MASK:   mask_q   <= wdata;
                    default:    ;
                endcase
            end
        end
    end

    assign arm_q = ctrl_q[CTL_ARM];

    always_comb begin
        case (sel)
            SEL_COUNT:  rdata = count_val;
            SEL_RELOAD: rdata = reload_q;
            SEL_CTRL:   rdata = ctrl_q;
            SEL_WIDTH:  rdata = width_q;
            SEL_MASK:   rdata = mask_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_count.sv
module kwd_count
    import kwd_pkg::*;
#(
    parameter logic [DW-1:0] INIT_LOAD = 32'h014F_B180
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  cnt_cmd_t      cmd,
    input  logic [DW-1:0] reload,
    input  logic          mc_flag,
    output logic [DW-1:0] count_q,
    output logic          fire,
    output logic          quench,
    output logic          expire_q
);
    logic run_q, step, due;

    assign step   = tick && run_q && !cmd.hold;
    assign due    = step && (count_q <= DW'(1));
    assign fire   = due && !mc_flag;
    assign quench = due && mc_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= INIT_LOAD;
            run_q    <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= fire;
            if (due) begin
                count_q <= '0;
                run_q   <= 1'b0;
            end else if (cmd.load) begin
                count_q <= reload;
                run_q   <= cmd.run_on_load;
            end else if (cmd.stop) begin
                run_q   <= 1'b0;
            end else if (step) begin
                count_q <= count_q - DW'(1);
            end
        end
    end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int unsigned FIELD_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic [FIELD_W-1:0] width,
    output logic               active
);
    logic [FIELD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= width;
        end else if (tick && (left_q != '0)) begin
            left_q <= left_q - FIELD_W'(1);
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned FIELD_W   = 20,
    parameter logic [31:0] INIT_LOAD = 32'h014F_B180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mc_reset_flag,
    output logic              expire_pulse,
    output logic              reset_out,
    output logic              reset_push_pull
);
    cnt_cmd_t      cmd_w;
    logic [DW-1:0] reload_w, width_w, count_w;
    logic          arm_w, fire_w, quench_w, pulse_on_w;

    kwd_regs #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .INIT_LOAD(INIT_LOAD), .INIT_WID(32'h0000_00FF)
    ) regs_i (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .quench(quench_w), .count_val(count_w), .rdata(bus_rdata),
        .reload_q(reload_w), .arm_q(arm_w), .width_q(width_w), .cmd(cmd_w)
    );

    kwd_count #(.INIT_LOAD(INIT_LOAD)) count_i (
        .clk(clk), .rst(rst), .tick(tick_en), .cmd(cmd_w), .reload(reload_w),
        .mc_flag(mc_reset_flag), .count_q(count_w), .fire(fire_w),
        .quench(quench_w), .expire_q(expire_pulse)
    );

    kwd_pulse #(.FIELD_W(FIELD_W)) pulse_i (
        .clk(clk), .rst(rst), .tick(tick_en), .start(fire_w && arm_w),
        .width(width_w[FIELD_W-1:0]), .active(pulse_on_w)
    );

    assign reset_out       = pulse_on_w ? width_w[WID_LVL] : !width_w[WID_LVL];
    assign reset_push_pull = width_w[WID_PP];
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned FIELD_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              expire_pulse,
    input logic [31:0]       count_q,
    input logic              quench,
    input logic              pulse_on
);
    p_expire_single_r6: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |=> !expire_pulse);

    p_expire_zero_r6: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |-> (count_q == 32'd0));

    p_expire_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |-> $past(tick_en));

    p_quench_silent_r8: assert property (@(posedge clk) disable iff (rst)
        quench |=> (!expire_pulse && !$rose(pulse_on)));

    p_ctrl_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (8'(bus_addr) == 8'h0C) |-> ((bus_rdata[11:8] == 4'd0) && (bus_rdata[4] || bus_rdata == 32'd0)));

    p_width_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (8'(bus_addr) == 8'h18) |-> (bus_rdata[29:FIELD_W] == '0));

    p_pulse_start_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_on) |-> expire_pulse);
endmodule

bind kwd_top kwd_checker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) chk_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .expire_pulse(expire_pulse), .count_q(count_w), .quench(quench_w), .pulse_on(pulse_on_w)
);

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        mc_reset_flag = 1'b0;
    logic [31:0] bus_rdata;
    logic        expire_pulse, reset_out, reset_push_pull;

    int checks = 0;
    int errors = 0;
    int exp_seen = 0;
    int hi_seen = 0;
    int lo_seen = 0;
    int cyc_n = 0;

    // reference model state
    logic [31:0] m_cnt, m_rel, m_ctl, m_wid, m_msk;
    logic        m_run, m_exp;
    int          m_left;

    always #10 clk = ~clk;

    kwd_top dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mc_reset_flag(mc_reset_flag),
        .expire_pulse(expire_pulse), .reset_out(reset_out), .reset_push_pull(reset_push_pull)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%08h exp=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_cnt;
            5'h04:   return m_rel;
            5'h0C:   return m_ctl;
            5'h18:   return m_wid;
            5'h1C:   return m_msk;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        logic blk, due, fire;
        logic [31:0] d;
        if (rst) begin
            m_cnt = 32'h014FB180; m_rel = 32'h014FB180; m_ctl = 32'h10;
            m_wid = 32'hFF; m_msk = 0; m_run = 0; m_exp = 0; m_left = 0;
        end else begin
            blk  = bus_wr && (bus_addr == 5'h0C || (bus_addr == 5'h08 && bus_wdata[15:0] == 16'h4755));
            due  = tick_en && m_run && !blk && (m_cnt <= 1);
            fire = due && !mc_reset_flag;
            if (fire && m_ctl[1]) m_left = int'(m_wid[19:0]);
            else if (tick_en && m_left > 0) m_left = m_left - 1;
            if (due) begin
                m_cnt = 0; m_run = 0;
                if (mc_reset_flag) m_ctl = 0;
            end else if (tick_en && m_run && !blk) begin
                m_cnt = m_cnt - 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    5'h04: m_rel = bus_wdata;
                    5'h08: if (bus_wdata[15:0] == 16'h4755) begin m_cnt = m_rel; m_run = m_ctl[0]; end
                    5'h0C: begin
                        d = (bus_wdata & ~32'hF00) | 32'h10;
                        if (d[0] && !m_ctl[0]) begin m_cnt = m_rel; m_run = 1; end
                        else if (!d[0] && m_ctl[0]) m_run = 0;
                        m_ctl = d;
                    end
                    5'h18: begin
                        m_wid[19:0] = bus_wdata[19:0];
                        if (bus_wdata[31:24] == 8'hA5) m_wid[31] = 1;
                        else if (bus_wdata[31:24] == 8'h5A) m_wid[31] = 0;
                        else if (bus_wdata[31:24] == 8'hA8) m_wid[30] = 1;
                        else if (bus_wdata[31:24] == 8'h8A) m_wid[30] = 0;
                    end
                    5'h1C: m_msk = bus_wdata;
                    default: ;
                endcase
            end
            m_exp = fire;
        end
    endtask

    always @(posedge clk) begin
        cyc_n++;
        model_step();
        #5;
        if (!rst) begin
            check("R6 expire_pulse", {31'd0, expire_pulse}, {31'd0, m_exp});
            check("R10 reset_out", {31'd0, reset_out},
                  {31'd0, (m_left > 0) ? m_wid[31] : !m_wid[31]});
            check("R9 reset_push_pull", {31'd0, reset_push_pull}, {31'd0, m_wid[30]});
            check("R2 bus_rdata", bus_rdata, m_read(bus_addr));
            if (expire_pulse) exp_seen++;
            if (reset_out) hi_seen++; else lo_seen++;
        end
        if (cyc_n > 20000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<20000", cyc_n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                       input logic tk, input logic h);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = tk; mc_reset_flag = h;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 32'd0, 1'b1, 1'b0);
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, a, 32'd0, 1'b0, 1'b0);
        #2;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_check(5'h00, 32'h014FB180, "R1 count");
        rd_check(5'h04, 32'h014FB180, "R1 reload");
        rd_check(5'h0C, 32'h00000010, "R1 ctrl");
        rd_check(5'h18, 32'h000000FF, "R1 width");
        rd_check(5'h1C, 32'h00000000, "R1 mask");
        // R2 map and ignored writes
        wr_reg(5'h00, 32'h12345678);
        rd_check(5'h00, 32'h014FB180, "R2 status write ignored");
        rd_check(5'h08, 32'h0, "R2 restart reads zero");
        rd_check(5'h14, 32'h0, "R2 unused reads zero");
        rd_check(5'h03, 32'h0, "R2 unaligned reads zero");
        wr_reg(5'h1C, 32'hCAFEF00D);
        rd_check(5'h1C, 32'hCAFEF00D, "R2 mask");
        // R3 sanitizing
        wr_reg(5'h0C, 32'hFFFFFFFE);
        rd_check(5'h0C, 32'hFFFFF0FE, "R3 ctrl clean");
        wr_reg(5'h0C, 32'h0);
        rd_check(5'h0C, 32'h00000010, "R3 ctrl forced bit");
        // R9 width keys
        wr_reg(5'h18, 32'hA5000003);
        rd_check(5'h18, 32'h80000003, "R9 key A5");
        wr_reg(5'h18, 32'h77000005);
        rd_check(5'h18, 32'h80000005, "R9 other key");
        wr_reg(5'h18, 32'hA8FFFFFF);
        rd_check(5'h18, 32'hC00FFFFF, "R9 key A8");
        check("R9 push-pull set", {31'd0, reset_push_pull}, 32'd1);
        wr_reg(5'h18, 32'h8A000004);
        rd_check(5'h18, 32'h80000004, "R9 key 8A");
        check("R9 push-pull clear", {31'd0, reset_push_pull}, 32'd0);
        // R4/R6 count to expiry, R10 high pulse of 4 ticks
        wr_reg(5'h04, 32'd5);
        hi_seen = 0;
        wr_reg(5'h0C, 32'h3);
        rd_check(5'h00, 32'd5, "R4 enable loads");
        idle(2);
        rd_check(5'h00, 32'd3, "R6 decrement");
        idle(10);
        check("R6 one expiry", exp_seen, 1);
        rd_check(5'h00, 32'd0, "R6 count zero");
        check("R10 high pulse ticks", hi_seen, 4);
        check("R10 idle level", {31'd0, reset_out}, 32'd0);
        // R5 keyed restart
        wr_reg(5'h04, 32'h20);
        wr_reg(5'h08, 32'h00004755);
        idle(4);
        rd_check(5'h00, 32'h1C, "R5 restart runs");
        wr_reg(5'h08, 32'h00004756);
        rd_check(5'h00, 32'h1C, "R5 wrong key ignored");
        wr_reg(5'h08, 32'hABCD4755);
        rd_check(5'h00, 32'h20, "R5 key in low half");
        idle(3);
        wr_reg(5'h0C, 32'h12);
        idle(5);
        rd_check(5'h00, 32'h1D, "R4 disable freezes");
        wr_reg(5'h0C, 32'h13);
        rd_check(5'h00, 32'h20, "R4 re-enable reloads");
        idle(2);
        wr_reg(5'h0C, 32'h17);
        rd_check(5'h00, 32'h1E, "R4 same-enable write");
        // R7 precedence with the final tick
        wr_reg(5'h04, 32'd1);
        wr_reg(5'h08, 32'h4755);
        wr_reg(5'h04, 32'd6);
        cyc(1'b1, 5'h08, 32'h4755, 1'b1, 1'b0);
        rd_check(5'h00, 32'd6, "R7 restart beats tick");
        check("R7 no expiry", exp_seen, 1);
        wr_reg(5'h04, 32'd1);
        wr_reg(5'h08, 32'h4755);
        cyc(1'b1, 5'h0C, 32'h13, 1'b1, 1'b0);
        rd_check(5'h00, 32'd1, "R7 ctrl write beats tick");
        idle(1);
        idle(6);
        check("R6 second expiry", exp_seen, 2);
        // R8 suppression
        wr_reg(5'h08, 32'h4755);
        cyc(1'b0, 5'h00, 32'd0, 1'b1, 1'b1);
        rd_check(5'h0C, 32'd0, "R8 ctrl cleared");
        rd_check(5'h00, 32'd0, "R8 count zero");
        idle(3);
        check("R8 no expiry", exp_seen, 2);
        check("R8 no reset", {31'd0, reset_out}, 32'd0);
        // R10 width zero, then active-low pulse of 2 ticks
        wr_reg(5'h18, 32'h5A000000);
        lo_seen = 0;
        wr_reg(5'h04, 32'd2);
        wr_reg(5'h0C, 32'h3);
        idle(6);
        check("R6 third expiry", exp_seen, 3);
        check("R10 zero width", lo_seen, 0);
        wr_reg(5'h18, 32'h00000002);
        wr_reg(5'h08, 32'h4755);
        idle(6);
        check("R10 low pulse ticks", lo_seen, 2);
        wr_reg(5'h18, 32'hA8000002);
        idle(1);
        check("R9 push-pull after key", {31'd0, reset_push_pull}, 32'd1);
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule